// File: doc/BRIEF.md
# Seconds Counter with Tick Prescaler and Alarm

This block keeps time for a chip. A one-cycle tick enable arrives at 32.768 kHz, and a reloadable prescaler divides it down. Each time the prescaler runs out, a 32-bit counter advances by one. The counter is also checked against an alarm value. Three events raise sticky flags: a completed period, an alarm match and a counter wrap. Each flag has its own interrupt enable, and the enabled flags are combined into a single registered interrupt line.

Software reaches the block over a 16-bit register bus with byte addresses. The prescaler reload, the counter and the alarm can only be changed through a configuration session. Software sets a configuration bit and writes the new values, which are held aside. It then clears the bit, and the staged values are applied on the third tick after that. A done bit reads 0 while this commit is pending and returns to 1 once it has taken effect.

Top module: `rtcnt_top`

## Requirements
- R1: After reset the control word at 0x04 reads 0x0020, the enables at 0x00 read 0, the reload reads 0x0_7FFF (high bits at 0x08, low 16 bits at 0x0C), the divider reads 0x7FFF, the counter reads 0, the alarm reads 0xFFFFFFFF and irq is 0.
- R2: The divider counts down by one on each tick and restarts from the reload value on the tick after it reads 0, so one period lasts reload+1 ticks. It reads at 0x10 (high bits) and 0x14 (low 16 bits), and writes to those addresses are ignored.
- R3: When a period ends, the counter, read as 0x18 (upper half) and 0x1C (lower half), goes up by one and the second flag (bit 0 of 0x04) is set.
- R4: An increment from 0xFFFFFFFF gives 0 and sets the overflow flag (bit 2 of 0x04).
- R5: An increment that makes the counter equal to the alarm (0x20 upper half, 0x24 lower half) sets the alarm flag (bit 1 of 0x04).
- R6: Writes to 0x08, 0x0C, 0x18, 0x1C, 0x20 and 0x24 are ignored while the configuration bit (bit 4 of 0x04) is 0.
- R7: Writes made while the configuration bit is 1 change nothing that can be read until a commit. Writing 0 to the configuration bit starts the commit and makes the done bit (bit 5 of 0x04) read 0. On the third tick after that, the staged values take effect, the divider restarts from a newly written reload, and the done bit reads 1 again.
- R8: Writing 0 to bit 0, 1, 2 or 3 of 0x04 clears that flag, and writing 1 has no effect. Bit 3 is set by every tick. An event in the same cycle as a clear write wins.
- R9: One clock after the flags or enables change, irq equals the OR over bits 0 to 2 of each flag ANDed with its enable at 0x00.
- R10: A write that sets the configuration bit while a commit is pending is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle pulse at the 32.768 kHz rate |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 6 | Byte address of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the clock after the read |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench brings the prescaler right up to the end of a period and steps over it. A design that was off by one in the reload count would move the counter one tick early or late. It checks that the done bit stays low for exactly two ticks after the configuration bit is cleared, and that the staged counter, reload and alarm values appear only on the third tick. A commit on the wrong tick, or live writes during the session, would show up as wrong readback. It also crosses the counter wrap from all ones and the alarm match. It writes 1s to flags that are set and tries to re-enter configuration during a commit. A design that cleared flags on a write of 1 or that accepted the late configuration request would then read back the wrong flags or the wrong counter.

// File: rtl/rtcnt_pkg.sv
package rtcnt_pkg;
  localparam int DW = 16;
  localparam int AW = 6;

  localparam logic [AW-1:0] A_IEN  = 6'h00;
  localparam logic [AW-1:0] A_CTRL = 6'h04;
  localparam logic [AW-1:0] A_RLDH = 6'h08;
  localparam logic [AW-1:0] A_RLDL = 6'h0C;
  localparam logic [AW-1:0] A_DIVH = 6'h10;
  localparam logic [AW-1:0] A_DIVL = 6'h14;
  localparam logic [AW-1:0] A_CNTH = 6'h18;
  localparam logic [AW-1:0] A_CNTL = 6'h1C;
  localparam logic [AW-1:0] A_ALMH = 6'h20;
  localparam logic [AW-1:0] A_ALML = 6'h24;

  localparam int B_SEC  = 0;
  localparam int B_ALM  = 1;
  localparam int B_OVF  = 2;
  localparam int B_SYNC = 3;
  localparam int B_CFG  = 4;
  localparam int B_DONE = 5;
  localparam int NFLAG  = 3;
endpackage

// File: rtl/rtcnt_prescaler.sv
module rtcnt_prescaler #(
  parameter int PW = 20,
  parameter logic [PW-1:0] RST_RELOAD = PW'(32767)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          load,
  input  logic [PW-1:0] load_val,
  output logic [PW-1:0] reload,
  output logic [PW-1:0] div,
  output logic          wrap
);
  assign wrap = tick && !load && (div == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      reload <= RST_RELOAD;
      div    <= RST_RELOAD;
    end else if (load) begin
      reload <= load_val;
      div    <= load_val;
    end else if (tick) begin
      div <= (div == '0) ? reload : div - PW'(1);
    end
  end

  // R2: the divider never exceeds the reload value
  a_r2_div_bound: assert property (@(posedge clk) disable iff (rst)
    div <= reload);
  // R2: a wrap restarts the divider from the reload value
  a_r2_wrap_refill: assert property (@(posedge clk) disable iff (rst)
    wrap |=> div == $past(reload));
  // R2: with no tick and no load the divider holds
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!tick && !load) |=> $stable(div));
endmodule

// File: rtl/rtcnt_counter.sv
module rtcnt_counter #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc,
  input  logic          ld_cnt,
  input  logic [CW-1:0] cnt_in,
  input  logic          ld_alm,
  input  logic [CW-1:0] alm_in,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] alarm,
  output logic          alm_hit,
  output logic          ovf_hit
);
  logic [CW-1:0] cnt_inc;
  logic          step;

  assign cnt_inc = cnt + CW'(1);
  assign step    = inc && !ld_cnt;
  assign alm_hit = step && (cnt_inc == alarm);
  assign ovf_hit = step && (&cnt);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      alarm <= '1;
    end else begin
      if (ld_cnt)    cnt <= cnt_in;
      else if (inc)  cnt <= cnt_inc;
      if (ld_alm)    alarm <= alm_in;
    end
  end

  // R3: an increment adds exactly one
  a_r3_step: assert property (@(posedge clk) disable iff (rst)
    (inc && !ld_cnt) |=> cnt == $past(cnt) + CW'(1));
  // R4: an overflow event leaves the counter at zero
  a_r4_wrap_zero: assert property (@(posedge clk) disable iff (rst)
    ovf_hit |=> cnt == '0);
  // R7: a committed counter value lands as written
  a_r7_load: assert property (@(posedge clk) disable iff (rst)
    ld_cnt |=> cnt == $past(cnt_in));
  // R5: an alarm event leaves the counter equal to the alarm
  a_r5_match: assert property (@(posedge clk) disable iff (rst)
    (alm_hit && !ld_alm) |=> cnt == alarm);
endmodule

// File: rtl/rtcnt_commit.sv
module rtcnt_commit #(
  parameter int WAIT = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic start,
  output logic busy,
  output logic fire
);
  localparam int CW = $clog2(WAIT + 1);
  logic [CW-1:0] seen;

  assign fire = busy && tick && (seen == CW'(WAIT - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      seen <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      seen <= '0;
    end else if (fire) begin
      busy <= 1'b0;
    end else if (busy && tick) begin
      seen <= seen + CW'(1);
    end
  end

  // R7: the commit ends on the tick that fires it
  a_r7_fire_ends: assert property (@(posedge clk) disable iff (rst)
    fire |=> !busy);
  // R7: a start request opens a commit
  a_r7_start: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);
  // R7: no commit appears without a start
  a_r7_quiet: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> !busy);
endmodule

// File: rtl/rtcnt_top.sv
module rtcnt_top #(
  parameter int              PRE_W        = 20,
  parameter int              COMMIT_TICKS = 3,
  parameter logic [PRE_W-1:0] PRE_RESET   = PRE_W'(32767)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        tick_en,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [5:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        irq
);
  import rtcnt_pkg::*;

  localparam int CNT_W  = 2 * DW;
  localparam int PRE_HI = PRE_W - DW;

  logic wr, rd, wr_ctrl;
  logic [NFLAG-1:0] ien, flg, evt, clr;
  logic sync, cfg;
  logic enter_cfg, leave_cfg;
  logic busy, fire;
  logic [PRE_W-1:0] stage_pre, reload, div;
  logic [CNT_W-1:0] stage_cnt, stage_alm, cnt, alarm;
  logic dirty_pre, dirty_cnt, dirty_alm;
  logic wrap, alm_hit, ovf_hit;
  logic [DW-1:0] rd_mux;

  assign wr      = bus_sel && bus_wr;
  assign rd      = bus_sel && !bus_wr;
  assign wr_ctrl = wr && (bus_addr == A_CTRL);
  assign enter_cfg = wr_ctrl && bus_wdata[B_CFG] && !cfg && !busy;
  assign leave_cfg = wr_ctrl && !bus_wdata[B_CFG] && cfg;

  rtcnt_prescaler #(.PW(PRE_W), .RST_RELOAD(PRE_RESET)) u_pre (
    .clk(clk), .rst(rst), .tick(tick_en),
    .load(fire && dirty_pre), .load_val(stage_pre),
    .reload(reload), .div(div), .wrap(wrap));

  rtcnt_counter #(.CW(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .inc(wrap),
    .ld_cnt(fire && dirty_cnt), .cnt_in(stage_cnt),
    .ld_alm(fire && dirty_alm), .alm_in(stage_alm),
    .cnt(cnt), .alarm(alarm), .alm_hit(alm_hit), .ovf_hit(ovf_hit));

  rtcnt_commit #(.WAIT(COMMIT_TICKS)) u_commit (
    .clk(clk), .rst(rst), .tick(tick_en), .start(leave_cfg),
    .busy(busy), .fire(fire));

  // configuration session and staging
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg       <= 1'b0;
      stage_pre <= PRE_RESET;
      stage_cnt <= '0;
      stage_alm <= '1;
      dirty_pre <= 1'b0;
      dirty_cnt <= 1'b0;
      dirty_alm <= 1'b0;
    end else begin
      if (enter_cfg) begin
        cfg       <= 1'b1;
        stage_pre <= reload;
        stage_cnt <= cnt;
        stage_alm <= alarm;
        dirty_pre <= 1'b0;
        dirty_cnt <= 1'b0;
        dirty_alm <= 1'b0;
      end else if (leave_cfg) begin
        cfg <= 1'b0;
      end else if (cfg && wr) begin
        case (bus_addr)
          A_RLDH: begin stage_pre[PRE_W-1:DW] <= bus_wdata[PRE_HI-1:0]; dirty_pre <= 1'b1; end
          A_RLDL: begin stage_pre[DW-1:0]     <= bus_wdata;             dirty_pre <= 1'b1; end
          A_CNTH: begin stage_cnt[CNT_W-1:DW] <= bus_wdata;             dirty_cnt <= 1'b1; end
          A_CNTL: begin stage_cnt[DW-1:0]     <= bus_wdata;             dirty_cnt <= 1'b1; end
          A_ALMH: begin stage_alm[CNT_W-1:DW] <= bus_wdata;             dirty_alm <= 1'b1; end
          A_ALML: begin stage_alm[DW-1:0]     <= bus_wdata;             dirty_alm <= 1'b1; end
          default: ;
        endcase
      end else if (fire) begin
        dirty_pre <= 1'b0;
        dirty_cnt <= 1'b0;
        dirty_alm <= 1'b0;
      end
    end
  end

  // sticky flags: events win over write-zero clears
  assign evt = {ovf_hit, alm_hit, wrap};
  assign clr = wr_ctrl ? ~bus_wdata[NFLAG-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      flg  <= '0;
      sync <= 1'b0;
      ien  <= '0;
      irq  <= 1'b0;
    end else begin
      flg  <= evt | (flg & ~clr);
      sync <= tick_en | (sync & !(wr_ctrl && !bus_wdata[B_SYNC]));
      if (wr && bus_addr == A_IEN) ien <= bus_wdata[NFLAG-1:0];
      irq  <= |(flg & ien);
    end
  end

  // readback
  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      A_IEN:  rd_mux = DW'(ien);
      A_CTRL: rd_mux = DW'({!busy, cfg, sync, flg});
      A_RLDH: rd_mux = DW'(reload[PRE_W-1:DW]);
      A_RLDL: rd_mux = reload[DW-1:0];
      A_DIVH: rd_mux = DW'(div[PRE_W-1:DW]);
      A_DIVL: rd_mux = div[DW-1:0];
      A_CNTH: rd_mux = cnt[CNT_W-1:DW];
      A_CNTL: rd_mux = cnt[DW-1:0];
      A_ALMH: rd_mux = alarm[CNT_W-1:DW];
      A_ALML: rd_mux = alarm[DW-1:0];
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     bus_rdata <= '0;
    else if (rd) bus_rdata <= rd_mux;
  end

  // R3: the second flag only rises after a period end
  a_r3_sec_source: assert property (@(posedge clk) disable iff (rst)
    $rose(flg[B_SEC]) |-> $past(wrap));
  // R4: the overflow flag only rises after a counter wrap
  a_r4_ovf_source: assert property (@(posedge clk) disable iff (rst)
    $rose(flg[B_OVF]) |-> $past(ovf_hit));
  // R10: no configuration session while a commit is pending
  a_r10_no_cfg_busy: assert property (@(posedge clk) disable iff (rst)
    busy |-> !cfg);
  // R9: with all enables off the interrupt stays low
  a_r9_gated: assert property (@(posedge clk) disable iff (rst)
    ($past(ien) == '0) |-> !irq);
  // R6: outside a session the staged values cannot change
  a_r6_stage_hold: assert property (@(posedge clk) disable iff (rst)
    (!cfg && !enter_cfg) |=> ($stable(stage_cnt) && $stable(stage_pre) && $stable(stage_alm)));
endmodule

// File: tb/rtcnt_top_test.sv
`timescale 1ns/1ps
module rtcnt_top_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  rtcnt_top uut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rd32(input logic [5:0] ahi, output logic [31:0] v);
    logic [15:0] h, l;
    rd(ahi, h);
    rd(ahi + 6'h04, l);
    v = {h, l};
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_en = 1'b1;
      @(posedge clk);
      @(negedge clk); tick_en = 1'b0;
      @(posedge clk);
    end
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] d; logic [31:0] v;
    rd(6'h04, d); check("R1 ctrl", {16'h0, d}, 32'h0020);
    rd(6'h00, d); check("R1 ien", {16'h0, d}, 32'h0);
    rd32(6'h08, v); check("R1 reload", v, 32'h0000_7FFF);
    rd(6'h14, d); check("R1 divider", {16'h0, d}, 32'h7FFF);
    rd32(6'h18, v); check("R1 counter", v, 32'h0);
    rd32(6'h20, v); check("R1 alarm", v, 32'hFFFF_FFFF);
    check("R1 irq", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_idle_writes();
    logic [15:0] d; logic [31:0] v;
    tick(1);
    rd(6'h14, d); check("R2 divider step", {16'h0, d}, 32'h7FFE);
    wr(6'h14, 16'h1234);
    rd(6'h14, d); check("R2 divider read-only", {16'h0, d}, 32'h7FFE);
    wr(6'h1C, 16'h0005);
    rd32(6'h18, v); check("R6 counter write outside session", v, 32'h0);
    rd(6'h04, d); check("R8 sync set by tick", {16'h0, d}, 32'h0028);
  endtask

  task automatic t_commit();
    logic [15:0] d; logic [31:0] v;
    wr(6'h04, 16'h001F);
    rd(6'h04, d); check("R8 write one no effect / session open", {16'h0, d}, 32'h0038);
    wr(6'h08, 16'h0000); wr(6'h0C, 16'h0003);
    wr(6'h18, 16'h0000); wr(6'h1C, 16'h000A);
    wr(6'h20, 16'h0000); wr(6'h24, 16'h000C);
    rd32(6'h18, v); check("R7 counter staged", v, 32'h0);
    rd(6'h0C, d); check("R7 reload staged", {16'h0, d}, 32'h7FFF);
    wr(6'h04, 16'h000F);
    rd(6'h04, d); check("R7 done low during commit", {16'h0, d}, 32'h0008);
    tick(2);
    rd(6'h04, d); check("R7 done low after two ticks", {16'h0, d}, 32'h0008);
    rd32(6'h18, v); check("R7 counter not yet applied", v, 32'h0);
    tick(1);
    rd32(6'h18, v); check("R7 counter applied", v, 32'd10);
    rd(6'h0C, d); check("R7 reload applied", {16'h0, d}, 32'h3);
    rd(6'h14, d); check("R7 divider restarted", {16'h0, d}, 32'h3);
    rd32(6'h20, v); check("R7 alarm applied", v, 32'd12);
    rd(6'h04, d); check("R7 done high", {16'h0, d}, 32'h0028);
  endtask

  task automatic t_period();
    logic [15:0] d; logic [31:0] v;
    tick(3);
    rd(6'h14, d); check("R2 divider at zero", {16'h0, d}, 32'h0);
    rd32(6'h18, v); check("R3 no early increment", v, 32'd10);
    tick(1);
    rd32(6'h18, v); check("R3 increment at period end", v, 32'd11);
    rd(6'h14, d); check("R2 divider refill", {16'h0, d}, 32'h3);
    rd(6'h04, d); check("R3 second flag", {16'h0, d}, 32'h0029);
    wr(6'h04, 16'h000E);
    rd(6'h04, d); check("R8 clear second flag", {16'h0, d}, 32'h0028);
  endtask

  task automatic t_alarm();
    logic [15:0] d; logic [31:0] v;
    tick(4);
    rd32(6'h18, v); check("R5 counter at alarm", v, 32'd12);
    rd(6'h04, d); check("R5 alarm flag", {16'h0, d}, 32'h002B);
    wr(6'h04, 16'h000F);
    rd(6'h04, d); check("R8 write one keeps flags", {16'h0, d}, 32'h002B);
    wr(6'h04, 16'h0000);
    rd(6'h04, d); check("R8 write zero clears all", {16'h0, d}, 32'h0020);
  endtask

  task automatic t_irq();
    logic [15:0] d;
    wr(6'h00, 16'h0002);
    tick(4);
    @(negedge clk);
    check("R9 masked flag gives no irq", {31'h0, irq}, 32'h0);
    wr(6'h00, 16'h0001);
    @(negedge clk);
    check("R9 enabled second flag raises irq", {31'h0, irq}, 32'h1);
    rd(6'h00, d); check("R9 enable readback", {16'h0, d}, 32'h1);
    wr(6'h04, 16'h0000);
    @(negedge clk);
    check("R9 irq drops after clear", {31'h0, irq}, 32'h0);
    wr(6'h00, 16'h0000);
  endtask

  task automatic t_overflow();
    logic [15:0] d; logic [31:0] v;
    wr(6'h04, 16'h0010);
    wr(6'h0C, 16'h0003);
    wr(6'h18, 16'hFFFF); wr(6'h1C, 16'hFFFF);
    wr(6'h04, 16'h0000);
    tick(3);
    rd32(6'h18, v); check("R7 counter loaded all ones", v, 32'hFFFF_FFFF);
    tick(3);
    rd32(6'h18, v); check("R4 before wrap", v, 32'hFFFF_FFFF);
    tick(1);
    rd32(6'h18, v); check("R4 wrap to zero", v, 32'h0);
    rd(6'h04, d); check("R4 overflow flag", {16'h0, d}, 32'h002D);
  endtask

  task automatic t_busy_lock();
    logic [15:0] d; logic [31:0] v;
    wr(6'h04, 16'h0010);
    wr(6'h1C, 16'd100);
    wr(6'h04, 16'h0000);
    wr(6'h04, 16'h0010);
    rd(6'h04, d); check("R10 session refused while busy", {16'h0, d}, 32'h0000);
    wr(6'h1C, 16'h0007);
    tick(3);
    rd32(6'h18, v); check("R10 commit keeps staged value", v, 32'd100);
    rd(6'h04, d); check("R10 done after commit", {16'h0, d}, 32'h0028);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_idle_writes();
    t_commit();
    t_period();
    t_alarm();
    t_irq();
    t_overflow();
    t_busy_lock();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule